// File: doc/BRIEF.md
# PLL Multiplier and Pre-Divider Setting Search

This block works out the integer loop multiplier M and the reference pre-divider N that bring a PLL closest to a requested output rate, given the reference rate. It takes the field widths of M, N and an optional fractional term at run time, together with an allowed multiplier window and a rounding policy. It walks N upward from 1. For each N it derives an M, evaluates the rate that pair produces, and keeps the best candidate under the selected policy. When a fractional field is configured and the integer result is not exact, it then computes a clamped fractional correction for the chosen pair and reports the rate that results.

A second operation evaluates a given (M, N, fraction) setting and returns its rate, reporting 0 when N is zero. Both operations share one restoring shift-subtract divider. The divider takes 65 cycles per quotient, and each candidate costs two quotients. Operation is a start/done handshake. Every input is captured on the accepted start pulse and stays captured until done.

Top module: `pll_srch_top`

## Requirements
- R1: The reported rate for a setting is ceil((ref × M + ceil(ref × frac / 2^W)) / N), where W is the fractional width (f_bits, 0 = no fractional field) and frac is masked to W bits.
- R2: With op_eval = 1 and set_n = 0, the block completes with ok = 1 and res_rate = 0, without dividing.
- R3: A search tries N = 1, 2, 3, … and ends when N reaches 2^n_bits; res_n is always below 2^n_bits.
- R4: For N = 1 only, a request at or below m_min × ref uses M = m_min, and one at or above m_max × ref uses M = m_max. Either case evaluates that single candidate and ends the search.
- R5: Otherwise M = floor(req × N / ref), or (req × N + floor(ref/2)) / ref when nearest rounding is in effect. An M of 2^m_bits or more ends the search without evaluating that candidate.
- R6: Under nearest rounding a candidate replaces the best when its absolute error is strictly smaller. Under round-down it replaces the best only when it does not exceed the request and is strictly greater than the best so far (the best starts at 0).
- R7: Nearest rounding of M and nearest selection are in effect only when round_near = 1 and f_bits = 0. With a fractional field, the search always uses round-down.
- R8: A candidate that becomes the best with a rate equal to the request stops the search at once. If no candidate yields a nonzero best, or if ref or req is 0, the block completes with err = 1.
- R9: With f_bits > 0 and an inexact integer result, frac = min(q − M × 2^W, 2^W − 1), where q = req × N × 2^W / ref. The division q is rounded to nearest when round_near = 1 and floored otherwise. frac is 0 when req < floor(ref × M / N).
- R10: busy rises the cycle after an accepted start and stays high through the one-cycle done pulse. done comes with exactly one of ok and err. A start while busy is ignored, and so are input changes during an operation.
- R11: After reset, busy, done, ok, err and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Starts an operation when idle |
| op_eval | input | 1 | 1 = evaluate a given setting, 0 = search |
| ref_rate | input | RW | Reference rate |
| req_rate | input | RW | Requested output rate |
| m_bits | input | MBW | Width of the M field |
| n_bits | input | NBW | Width of the N field |
| f_bits | input | FBW | Width of the fractional field, 0 if absent |
| m_min | input | MW | Lowest allowed multiplier |
| m_max | input | MW | Highest allowed multiplier |
| round_near | input | 1 | Rounding flag (nearest when set) |
| set_m | input | MW | M for the evaluate operation |
| set_n | input | NW | N for the evaluate operation |
| set_frac | input | FW | Fraction for the evaluate operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Result valid |
| err | output | 1 | No usable setting |
| res_m | output | MW | Chosen or evaluated M |
| res_n | output | NW | Chosen or evaluated N |
| res_frac | output | FW | Fractional term |
| res_rate | output | 64 | Achieved rate |

## Verification
busy is due one cycle after the start pulse is sampled. The bench checks it at the falling edge that follows the start edge. The latency of done depends on the data: each candidate adds two 65-cycle divisions plus one or two issue cycles, and the fractional tail adds up to three more divisions. The bench therefore does not predict the done cycle. It polls done at every falling edge, samples ok, err and the results in that same cycle, and checks one cycle later that done and busy have dropped. Expected settings come from a bench-side model of the requirements, and a few corner cases are also compared against constants worked out by hand.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
  localparam int unsigned DW = 64;
  typedef logic [DW-1:0] wide_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CAND,
    ST_MDIV,
    ST_RATE,
    ST_RDIV,
    ST_FIN,
    ST_FCHK,
    ST_FDIV,
    ST_FRATE,
    ST_FRDIV,
    ST_DONE
  } st_e;
endpackage

// File: rtl/pll_srch_div.sv
module pll_srch_div
  import pll_srch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  input  wide_t dividend,
  input  wide_t divisor,
  output logic  done,
  output wide_t quo
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW:0]   rem_q, rem_d;
  wide_t         q_q, q_d;
  wide_t         dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic [DW:0]   shifted;
  logic [DW:0]   trial;

  always_comb begin
    shifted = {rem_q[DW-1:0], q_q[DW-1]};
    trial   = shifted - {1'b0, dvs_q};
    rem_d   = rem_q;
    q_d     = q_q;
    dvs_d   = dvs_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    if (go) begin
      rem_d = '0;
      q_d   = dividend;
      dvs_d = divisor;
      cnt_d = CW'(DW);
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q != '0) begin
        if (!trial[DW]) begin
          rem_d = trial;
          q_d   = {q_q[DW-2:0], 1'b1};
        end else begin
          rem_d = shifted;
          q_d   = {q_q[DW-2:0], 1'b0};
        end
        cnt_d = cnt_q - CW'(1);
      end else begin
        act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      q_q   <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      q_q   <= q_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign done = act_q && (cnt_q == '0);
  assign quo  = q_q;
endmodule

// File: rtl/pll_srch_pick.sv
module pll_srch_pick
  import pll_srch_pkg::*;
(
  input  wide_t target,
  input  wide_t best,
  input  wide_t cand,
  input  logic  nearest,
  output logic  better
);
  wide_t err_cand;
  wide_t err_best;

  always_comb begin
    err_cand = (cand >= target) ? (cand - target) : (target - cand);
    err_best = (best >= target) ? (best - target) : (target - best);
    if (nearest) better = (err_cand < err_best);
    else         better = (cand <= target) && (best < cand);
  end
endmodule

// File: rtl/pll_srch_fsm.sv
module pll_srch_fsm
  import pll_srch_pkg::*;
#(
  parameter int RW  = 32,
  parameter int MW  = 16,
  parameter int NW  = 8,
  parameter int FW  = 20,
  parameter int MBW = 5,
  parameter int NBW = 4,
  parameter int FBW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           op_eval,
  input  logic [RW-1:0]  ref_rate,
  input  logic [RW-1:0]  req_rate,
  input  logic [MBW-1:0] m_bits,
  input  logic [NBW-1:0] n_bits,
  input  logic [FBW-1:0] f_bits,
  input  logic [MW-1:0]  m_min,
  input  logic [MW-1:0]  m_max,
  input  logic           round_near,
  input  logic [MW-1:0]  set_m,
  input  logic [NW-1:0]  set_n,
  input  logic [FW-1:0]  set_frac,
  output logic           div_go,
  output wide_t          div_num,
  output wide_t          div_den,
  input  logic           div_done,
  input  wide_t          div_quo,
  output wide_t          pk_target,
  output wide_t          pk_best,
  output logic           pk_nearest,
  input  logic           pk_better,
  output logic           busy,
  output logic           done,
  output logic           ok,
  output logic           err,
  output logic [MW-1:0]  res_m,
  output logic [NW-1:0]  res_n,
  output logic [FW-1:0]  res_frac,
  output wide_t          res_rate
);
  st_e            st_q, st_d;
  logic [RW-1:0]  in_q, in_d, rate_q, rate_d;
  logic [MBW-1:0] mb_q, mb_d;
  logic [NBW-1:0] nb_q, nb_d;
  logic [FBW-1:0] fb_q, fb_d;
  logic [MW-1:0]  lo_q, lo_d, hi_q, hi_d;
  logic           rn_q, rn_d;
  logic [NW:0]    n_q, n_d;
  logic [MW-1:0]  m_q, m_d, bm_q, bm_d;
  logic [NW-1:0]  bn_q, bn_d;
  logic [FW-1:0]  fr_q, fr_d;
  logic           last_q, last_d;
  wide_t          best_q, best_d;
  logic [MW-1:0]  r_m_q, r_m_d;
  logic [NW-1:0]  r_n_q, r_n_d;
  logic [FW-1:0]  r_fr_q, r_fr_d;
  wide_t          r_rate_q, r_rate_d;
  logic           ok_q, ok_d, err_q, err_d;

  wide_t in64, rq64, n64, m64, bm64, bn64, fr64;
  wide_t fmask, in_fmask, nlim, mlim, half_in;
  wide_t fd_base, fd_val, frac_up;
  logic  near_eff;

  assign in64     = wide_t'(in_q);
  assign rq64     = wide_t'(rate_q);
  assign n64      = wide_t'(n_q);
  assign m64      = wide_t'(m_q);
  assign bm64     = wide_t'(bm_q);
  assign bn64     = wide_t'(bn_q);
  assign fr64     = wide_t'(fr_q);
  assign fmask    = (wide_t'(1) << fb_q) - wide_t'(1);
  assign in_fmask = (wide_t'(1) << f_bits) - wide_t'(1);
  assign nlim     = wide_t'(1) << nb_q;
  assign mlim     = wide_t'(1) << mb_q;
  assign half_in  = in64 >> 1;
  assign near_eff = rn_q && (fb_q == '0);
  assign fd_base  = bm64 << fb_q;
  assign fd_val   = (div_quo < fd_base) ? '0 : (div_quo - fd_base);
  assign frac_up  = ((in64 * fr64) + fmask) >> fb_q;

  assign pk_target  = rq64;
  assign pk_best    = best_q;
  assign pk_nearest = near_eff;

  always_comb begin
    st_d = st_q;   in_d = in_q;   rate_d = rate_q;
    mb_d = mb_q;   nb_d = nb_q;   fb_d = fb_q;
    lo_d = lo_q;   hi_d = hi_q;   rn_d = rn_q;
    n_d  = n_q;    m_d  = m_q;    last_d = last_q;
    best_d = best_q; bm_d = bm_q; bn_d = bn_q; fr_d = fr_q;
    r_m_d = r_m_q; r_n_d = r_n_q; r_fr_d = r_fr_q; r_rate_d = r_rate_q;
    ok_d = ok_q;   err_d = err_q;
    div_go  = 1'b0;
    div_num = '0;
    div_den = wide_t'(1);
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          in_d = ref_rate;  rate_d = req_rate;
          mb_d = m_bits;    nb_d = n_bits;   fb_d = f_bits;
          lo_d = m_min;     hi_d = m_max;    rn_d = round_near;
          ok_d = 1'b0;      err_d = 1'b0;
          if (op_eval) begin
            bm_d = set_m;
            bn_d = set_n;
            fr_d = FW'(wide_t'(set_frac) & in_fmask);
            if (set_n == '0) begin
              r_rate_d = '0;
              r_m_d    = set_m;
              r_n_d    = set_n;
              r_fr_d   = FW'(wide_t'(set_frac) & in_fmask);
              ok_d     = 1'b1;
              st_d     = ST_DONE;
            end else begin
              st_d = ST_FRATE;
            end
          end else if ((ref_rate == '0) || (req_rate == '0)) begin
            err_d = 1'b1;
            st_d  = ST_DONE;
          end else begin
            n_d    = (NW+1)'(1);
            best_d = '0;
            last_d = 1'b0;
            st_d   = ST_CAND;
          end
        end
      end
      ST_CAND: begin
        if (n64 >= nlim) begin
          st_d = ST_FIN;
        end else if ((n64 == wide_t'(1)) && (rq64 <= wide_t'(lo_q) * in64)) begin
          m_d    = lo_q;
          last_d = 1'b1;
          st_d   = ST_RATE;
        end else if ((n64 == wide_t'(1)) && (rq64 >= wide_t'(hi_q) * in64)) begin
          m_d    = hi_q;
          last_d = 1'b1;
          st_d   = ST_RATE;
        end else begin
          div_go  = 1'b1;
          div_num = (rq64 * n64) + (near_eff ? half_in : '0);
          div_den = in64;
          st_d    = ST_MDIV;
        end
      end
      ST_MDIV: begin
        if (div_done) begin
          if (div_quo >= mlim) begin
            st_d = ST_FIN;
          end else begin
            m_d  = MW'(div_quo);
            st_d = ST_RATE;
          end
        end
      end
      ST_RATE: begin
        div_go  = 1'b1;
        div_num = (in64 * m64) + n64 - wide_t'(1);
        div_den = n64;
        st_d    = ST_RDIV;
      end
      ST_RDIV: begin
        if (div_done) begin
          if (pk_better) begin
            best_d = div_quo;
            bm_d   = m_q;
            bn_d   = NW'(n_q);
          end
          if ((pk_better && (div_quo == rq64)) || last_q) begin
            st_d = ST_FIN;
          end else begin
            n_d  = n_q + (NW+1)'(1);
            st_d = ST_CAND;
          end
        end
      end
      ST_FIN: begin
        if (best_q == '0) begin
          err_d = 1'b1;
          st_d  = ST_DONE;
        end else if ((fb_q == '0) || (best_q == rq64)) begin
          r_rate_d = best_q;
          r_m_d    = bm_q;
          r_n_d    = bn_q;
          r_fr_d   = '0;
          ok_d     = 1'b1;
          st_d     = ST_DONE;
        end else begin
          div_go  = 1'b1;
          div_num = in64 * bm64;
          div_den = bn64;
          st_d    = ST_FCHK;
        end
      end
      ST_FCHK: begin
        if (div_done) begin
          if (rq64 < div_quo) begin
            fr_d = '0;
            st_d = ST_FRATE;
          end else begin
            div_go  = 1'b1;
            div_num = ((rq64 * bn64) << fb_q) + (rn_q ? half_in : '0);
            div_den = in64;
            st_d    = ST_FDIV;
          end
        end
      end
      ST_FDIV: begin
        if (div_done) begin
          fr_d = FW'((fd_val > fmask) ? fmask : fd_val);
          st_d = ST_FRATE;
        end
      end
      ST_FRATE: begin
        div_go  = 1'b1;
        div_num = (in64 * bm64) + frac_up + bn64 - wide_t'(1);
        div_den = bn64;
        st_d    = ST_FRDIV;
      end
      ST_FRDIV: begin
        if (div_done) begin
          r_rate_d = div_quo;
          r_m_d    = bm_q;
          r_n_d    = bn_q;
          r_fr_d   = fr_q;
          ok_d     = 1'b1;
          st_d     = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  in_q <= '0;  rate_q <= '0;
      mb_q <= '0;  nb_q <= '0;  fb_q <= '0;
      lo_q <= '0;  hi_q <= '0;  rn_q <= 1'b0;
      n_q  <= '0;  m_q  <= '0;  last_q <= 1'b0;
      best_q <= '0; bm_q <= '0; bn_q <= '0; fr_q <= '0;
      r_m_q <= '0; r_n_q <= '0; r_fr_q <= '0; r_rate_q <= '0;
      ok_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_d;  in_q <= in_d;  rate_q <= rate_d;
      mb_q <= mb_d;  nb_q <= nb_d;  fb_q <= fb_d;
      lo_q <= lo_d;  hi_q <= hi_d;  rn_q <= rn_d;
      n_q  <= n_d;   m_q  <= m_d;   last_q <= last_d;
      best_q <= best_d; bm_q <= bm_d; bn_q <= bn_d; fr_q <= fr_d;
      r_m_q <= r_m_d; r_n_q <= r_n_d; r_fr_q <= r_fr_d; r_rate_q <= r_rate_d;
      ok_q <= ok_d;  err_q <= err_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_DONE);
  assign ok       = ok_q;
  assign err      = err_q;
  assign res_m    = r_m_q;
  assign res_n    = r_n_q;
  assign res_frac = r_fr_q;
  assign res_rate = r_rate_q;
endmodule

// File: rtl/pll_srch_top.sv
module pll_srch_top
  import pll_srch_pkg::*;
#(
  parameter  int RW  = 32,
  parameter  int MW  = 16,
  parameter  int NW  = 8,
  parameter  int FW  = 20,
  localparam int MBW = $clog2(MW + 1),
  localparam int NBW = $clog2(NW + 1),
  localparam int FBW = $clog2(FW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           op_eval,
  input  logic [RW-1:0]  ref_rate,
  input  logic [RW-1:0]  req_rate,
  input  logic [MBW-1:0] m_bits,
  input  logic [NBW-1:0] n_bits,
  input  logic [FBW-1:0] f_bits,
  input  logic [MW-1:0]  m_min,
  input  logic [MW-1:0]  m_max,
  input  logic           round_near,
  input  logic [MW-1:0]  set_m,
  input  logic [NW-1:0]  set_n,
  input  logic [FW-1:0]  set_frac,
  output logic           busy,
  output logic           done,
  output logic           ok,
  output logic           err,
  output logic [MW-1:0]  res_m,
  output logic [NW-1:0]  res_n,
  output logic [FW-1:0]  res_frac,
  output logic [63:0]    res_rate
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       div_go, div_done, pk_nearest, pk_better;
  wide_t      div_num, div_den, div_quo, pk_target, pk_best;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pll_srch_fsm #(
    .RW(RW), .MW(MW), .NW(NW), .FW(FW), .MBW(MBW), .NBW(NBW), .FBW(FBW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .start(start), .op_eval(op_eval),
    .ref_rate(ref_rate), .req_rate(req_rate),
    .m_bits(m_bits), .n_bits(n_bits), .f_bits(f_bits),
    .m_min(m_min), .m_max(m_max), .round_near(round_near),
    .set_m(set_m), .set_n(set_n), .set_frac(set_frac),
    .div_go(div_go), .div_num(div_num), .div_den(div_den),
    .div_done(div_done), .div_quo(div_quo),
    .pk_target(pk_target), .pk_best(pk_best), .pk_nearest(pk_nearest),
    .pk_better(pk_better),
    .busy(busy), .done(done), .ok(ok), .err(err),
    .res_m(res_m), .res_n(res_n), .res_frac(res_frac), .res_rate(res_rate)
  );

  pll_srch_div u_div (
    .clk(clk), .rst_n(rst_int_n), .go(div_go),
    .dividend(div_num), .divisor(div_den),
    .done(div_done), .quo(div_quo)
  );

  pll_srch_pick u_pick (
    .target(pk_target), .best(pk_best), .cand(div_quo),
    .nearest(pk_nearest), .better(pk_better)
  );
endmodule

// File: rtl/pll_srch_chk.sv
module pll_srch_chk #(
  parameter int NW  = 8,
  parameter int FW  = 20,
  parameter int FBW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           ok,
  input logic           err,
  input logic [NW-1:0]  res_n,
  input logic [FW-1:0]  res_frac,
  input logic [FBW-1:0] f_bits,
  input logic [63:0]    res_rate
);
  assert_done_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok ^ err));

  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_zero_n_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok && (res_n == '0)) |-> (res_rate == 64'd0));

  assert_frac_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> (64'(res_frac) <= ((64'd1 << f_bits) - 64'd1)));
endmodule

bind pll_srch_top pll_srch_chk #(.NW(NW), .FW(FW), .FBW(FBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .ok(ok), .err(err), .res_n(res_n), .res_frac(res_frac),
  .f_bits(f_bits), .res_rate(res_rate)
);

// File: tb/sim_pll_srch_top.sv
`timescale 1ns/1ps
module sim_pll_srch_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_eval = 1'b0, round_near = 1'b0;
  logic [31:0] ref_rate = '0, req_rate = '0;
  logic [4:0]  m_bits = 5'd8;
  logic [3:0]  n_bits = 4'd3;
  logic [4:0]  f_bits = '0;
  logic [15:0] m_min = 16'd2, m_max = 16'd200, set_m = '0;
  logic [7:0]  set_n = '0;
  logic [19:0] set_frac = '0;
  logic        busy, done, ok, err;
  logic [15:0] res_m;
  logic [7:0]  res_n;
  logic [19:0] res_frac;
  logic [63:0] res_rate;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pll_srch_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_eval(op_eval),
    .ref_rate(ref_rate), .req_rate(req_rate), .m_bits(m_bits), .n_bits(n_bits),
    .f_bits(f_bits), .m_min(m_min), .m_max(m_max), .round_near(round_near),
    .set_m(set_m), .set_n(set_n), .set_frac(set_frac),
    .busy(busy), .done(done), .ok(ok), .err(err),
    .res_m(res_m), .res_n(res_n), .res_frac(res_frac), .res_rate(res_rate)
  );

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned absd(input longint unsigned a, input longint unsigned b);
    return (a >= b) ? a - b : b - a;
  endfunction

  task automatic model(output bit mok, output longint unsigned mm, mn, mf, mr);
    longint unsigned fin = ref_rate, frq = req_rate, best = 0, bm = 0, bn = 0;
    longint unsigned m, now, fmax, v;
    bit rce, lastc, better;
    mok = 0; mm = 0; mn = 0; mf = 0; mr = 0;
    if (fin == 0 || frq == 0) return;
    rce  = round_near && (f_bits == 0);
    fmax = 64'd1 << f_bits;
    for (longint unsigned n = 1; n < (64'd1 << n_bits); n++) begin
      lastc = 0;
      if (n == 1 && frq <= m_min * fin) begin m = m_min; lastc = 1; end
      else if (n == 1 && frq >= m_max * fin) begin m = m_max; lastc = 1; end
      else begin
        m = rce ? (frq * n + fin / 2) / fin : (frq * n) / fin;
        if (m >= (64'd1 << m_bits)) break;
      end
      now = (fin * m + n - 1) / n;
      if (rce) better = absd(now, frq) < absd(best, frq);
      else     better = (now <= frq) && (best < now);
      if (better) begin
        best = now; bm = m; bn = n;
        if (now == frq) break;
      end
      if (lastc) break;
    end
    if (best == 0) return;
    mok = 1; mm = bm; mn = bn;
    if (f_bits == 0 || best == frq) begin
      mr = best;
      return;
    end
    if (frq < (fin * bm) / bn) mf = 0;
    else begin
      v = round_near ? (frq * bn * fmax + fin / 2) / fin : (frq * bn * fmax) / fin;
      v = (v < bm * fmax) ? 0 : v - bm * fmax;
      mf = (v > fmax - 1) ? fmax - 1 : v;
    end
    mr = (fin * bm + (fin * mf + fmax - 1) / fmax + bn - 1) / bn;
  endtask

  // Starts an operation and waits for done; returns at the falling edge where done is high.
  task automatic go();
    int waited = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 busy one cycle after start", busy, 1);
    while (!done && waited < 30000) begin @(negedge clk); waited++; end
    chk("R10 done reached", done, 1);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk("R10 done is a single-cycle pulse", done, 0);
    chk("R10 idle after done", busy, 0);
  endtask

  task automatic search_case(input string tag, input int unsigned fin, frq,
                             input int mb, nb, fb, input bit rn);
    bit mok; longint unsigned mm, mn, mf, mr;
    op_eval = 0; ref_rate = fin; req_rate = frq;
    m_bits = 5'(mb); n_bits = 4'(nb); f_bits = 5'(fb); round_near = rn;
    model(mok, mm, mn, mf, mr);
    go();
    chk({tag, " ok"}, ok, mok);
    chk({tag, " err"}, err, !mok);
    if (mok) begin
      chk({tag, " M"}, res_m, mm);
      chk({tag, " N"}, res_n, mn);
      chk({tag, " frac"}, res_frac, mf);
      chk({tag, " rate"}, res_rate, mr);
      chk({tag, " R3 N below field limit"}, (64'(res_n) < (64'd1 << nb)), 1);
    end
    after_done();
  endtask

  task automatic t_reset();
    chk("R11 busy after reset", busy, 0);
    chk("R11 done after reset", done, 0);
    chk("R11 ok after reset", ok, 0);
    chk("R11 err after reset", err, 0);
    chk("R11 rate after reset", res_rate, 0);
    chk("R11 M after reset", res_m, 0);
  endtask

  task automatic t_exact();
    search_case("R8 exact stop", 25, 1000, 8, 3, 0, 0);
    chk("R8 exact M=40", res_m, 40);
    chk("R8 exact N=1", res_n, 1);
    chk("R8 exact rate", res_rate, 1000);
  endtask

  task automatic t_policies();
    search_case("R6 round-down walk", 24, 1001, 8, 4, 0, 0);
    chk("R6 round-down never above request", (res_rate <= 1001), 1);
    search_case("R6 R5 nearest walk", 24, 1001, 8, 4, 0, 1);
    search_case("R6 round-down other ref", 27, 2005, 9, 4, 0, 0);
  endtask

  task automatic t_clamp();
    m_min = 16'd2; m_max = 16'd200;
    search_case("R4 low clamp round-down", 25, 30, 8, 3, 0, 0);
    chk("R4 R8 low clamp round-down gives error", err, 1);
    search_case("R4 low clamp nearest", 25, 30, 8, 3, 0, 1);
    chk("R4 low clamp M=min", res_m, 2);
    chk("R4 low clamp rate", res_rate, 50);
    search_case("R4 high clamp", 25, 10000, 8, 3, 0, 0);
    chk("R4 high clamp M=max", res_m, 200);
    chk("R4 high clamp N=1", res_n, 1);
    chk("R4 high clamp rate", res_rate, 5000);
  endtask

  task automatic t_limits();
    search_case("R5 M overflow ends search", 25, 3000, 4, 3, 0, 0);
    chk("R5 M overflow gives error", err, 1);
    search_case("R3 single N candidate", 24, 1001, 8, 1, 0, 0);
    chk("R3 single candidate M", res_m, 41);
    chk("R3 single candidate rate", res_rate, 984);
    search_case("R8 zero request", 25, 0, 8, 3, 0, 0);
    chk("R8 zero request error", err, 1);
  endtask

  task automatic t_frac();
    search_case("R9 R1 frac round-down", 24, 1001, 8, 4, 12, 0);
    chk("R9 frac nonzero", (res_frac != 0), 1);
    search_case("R9 R7 frac with nearest flag", 24, 1001, 8, 4, 12, 1);
    search_case("R9 frac small field clamp", 7, 1000, 10, 3, 2, 0);
  endtask

  task automatic t_eval();
    op_eval = 1; ref_rate = 100; set_m = 40; set_n = 0; set_frac = 128; f_bits = 8;
    go();
    chk("R2 zero N ok", ok, 1);
    chk("R2 zero N rate", res_rate, 0);
    after_done();
    set_n = 3;
    go();
    chk("R1 eval ok", ok, 1);
    chk("R1 eval rate", res_rate, 1350);
    after_done();
    set_n = 7; set_frac = 20'hFFFFF; f_bits = 4;
    go();
    // masked frac = 15: ceil(100*15/16)=94, ceil((4000+94)/7)=585
    chk("R1 eval frac masked to field", res_frac, 15);
    chk("R1 eval rate masked frac", res_rate, 585);
    after_done();
    op_eval = 0;
  endtask

  task automatic t_busy_ignore();
    bit mok; longint unsigned mm, mn, mf, mr;
    int waited = 0;
    op_eval = 0; ref_rate = 24; req_rate = 1001; m_bits = 8; n_bits = 4; f_bits = 0; round_near = 0;
    model(mok, mm, mn, mf, mr);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    req_rate = 777; round_near = 1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && waited < 30000) begin @(negedge clk); waited++; end
    chk("R10 start while busy ignored: rate", res_rate, mr);
    chk("R10 start while busy ignored: N", res_n, mn);
    after_done();
    round_near = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_exact();
    t_policies();
    t_clamp();
    t_limits();
    t_frac();
    t_eval();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule